// File: doc/BRIEF.md
# Display RAM Command and Address Controller

This block sits behind a byte-wide host bus of a dot-matrix display driver. Each strobed byte is either a command (selecting addresses or display modes) or a data byte for the display memory. The memory is held inside the block as nine pages of 132 byte-wide columns; the ninth page is the icon row, where only bit 0 is kept. A page register and an 8-bit column counter form the access address. The counter advances after each data access, sticks at the last column, and never moves the page.

Reads go through a read latch. A data read presents the byte captured by the previous data read, then refills the latch from the current address. The first read after an address change is therefore a dummy read. A read-modify-write mode holds the column on reads and advances it on writes, so a host can read a byte, change it and write it back in place. Command-side reads return a status byte. The mode flags, the scroll start line and a 3-bit power-control field are driven out to the display timing and analog parts of the chip.

Top module: `lcd_cmd_ctl`

## Requirements
- R1: After hardware reset: display off, normal (non-inverted) image, entire-on off, segment and common directions normal, bias 1/9 (bias_7th=0), read-modify-write off, start line 0, power field 0, page 0, column 0, bus_dout 0x00.
- R2: Command 0001_hhhh loads column bits 7..4 and 0000_llll loads column bits 3..0; the access address is shown on ram_page and ram_col.
- R3: Every data read or write advances the column by one until it reaches 0x83, where it stays; the page never changes through a data access; a new column command releases the stop.
- R4: Command 1011_pppp loads the page when pppp is 0 to 8 and is ignored for 9 to 15. A write to page 8 stores only bit 0; the other bits read back as 0.
- R5: Command 0xE0 enters read-modify-write, in which data reads leave the column unchanged while data writes still advance it; 0xEE leaves the mode.
- R6: bus_dout after a data read holds the byte latched by the previous data read, and the latch is then loaded from the current address; the first read after an address set returns stale data.
- R7: A command-side read puts the status byte on bus_dout: bit 7 busy (always 0), bit 6 the inverse of seg_rev, bit 5 the inverse of disp_on, bit 4 reset in progress (0), bits 3..0 zero.
- R8: Single-byte mode commands: 0xAE/0xAF display off/on, 0xA0/0xA1 segment direction normal/reversed, 0xA6/0xA7 inverse off/on, 0xA4/0xA5 entire-on off/on, 0xA2/0xA3 bias 1/9 or 1/7.
- R9: Command 1100_d*** sets com_rev to d; 01_llllll loads start_line; 00101_xyz loads pwr_ctl with xyz.
- R10: Command 0xE2 clears read-modify-write, start line, page, column and common direction, leaving display on, inverse, entire-on, segment direction, bias and power field as they were.
- R11: With the column above 0x83, a data write raises no ram_we and the column holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hardware reset |
| bus_stb | input | 1 | One-cycle byte strobe |
| bus_dat | input | 1 | 1 = data byte, 0 = command byte |
| bus_rd | input | 1 | 1 = read, 0 = write |
| bus_din | input | 8 | Command or write data byte |
| bus_dout | output | 8 | Read data or status byte |
| ram_page | output | 4 | Current page address |
| ram_col | output | 8 | Current column address |
| ram_we | output | 1 | Memory write enable |
| ram_wdata | output | 8 | Memory write data (icon page masked) |
| disp_on | output | 1 | Display enabled |
| inverse | output | 1 | Inverted image |
| all_on | output | 1 | Entire display lit |
| seg_rev | output | 1 | Reversed segment direction |
| com_rev | output | 1 | Reversed common direction |
| bias_7th | output | 1 | 1 = 1/7 bias, 0 = 1/9 bias |
| rmw_on | output | 1 | Read-modify-write active |
| start_line | output | 6 | Display start line |
| pwr_ctl | output | 3 | Power-control field |

## Verification
The bench drives the column to 0x82 and writes past the end: a counter that wraps would land at column 0 or bump the page, and a read-back of 0x83 would show the lost overwrite. It reads immediately after a column set and expects stale latch data, which a design reading memory directly would not return. Read-modify-write is checked with reads that must not move the column followed by a write that must, catching a design that freezes both or neither. The software reset is checked against both the fields it must clear and the mode flags it must keep, so an over- or under-reaching reset is reported.

// File: rtl/lcdc_pkg.sv
package lcdc_pkg;

  typedef enum logic [3:0] {
    OP_NONE, OP_COLLO, OP_COLHI, OP_PWR, OP_LINE, OP_DISP, OP_SEG, OP_INV,
    OP_ALLON, OP_BIAS, OP_PAGE, OP_COMDIR, OP_RMW_ON, OP_RMW_OFF, OP_SRST
  } op_e;

  function automatic op_e classify(input logic [7:0] b);
    op_e r;
    casez (b)
      8'b0000_????: r = OP_COLLO;
      8'b0001_????: r = OP_COLHI;
      8'b0010_1???: r = OP_PWR;
      8'b01??_????: r = OP_LINE;
      8'b1010_111?: r = OP_DISP;
      8'b1010_000?: r = OP_SEG;
      8'b1010_011?: r = OP_INV;
      8'b1010_010?: r = OP_ALLON;
      8'b1010_001?: r = OP_BIAS;
      8'b1011_????: r = OP_PAGE;
      8'b1100_????: r = OP_COMDIR;
      8'hE0:        r = OP_RMW_ON;
      8'hEE:        r = OP_RMW_OFF;
      8'hE2:        r = OP_SRST;
      default:      r = OP_NONE;
    endcase
    return r;
  endfunction

  // saturating advance of the column counter
  function automatic logic [7:0] next_col(input logic [7:0] c, input logic [7:0] last);
    return (c < last) ? c + 8'd1 : c;
  endfunction

  function automatic logic [7:0] status_byte(input logic seg_r, input logic on);
    return {1'b0, ~seg_r, ~on, 1'b0, 4'b0000};
  endfunction

endpackage

// File: rtl/lcdc_decode.sv
module lcdc_decode
  import lcdc_pkg::*;
(
  input  logic       stb,
  input  logic       is_dat,
  input  logic       is_rd,
  input  logic [7:0] byte_in,
  output op_e        op
);
  always_comb begin
    op = OP_NONE;
    if (stb && !is_dat && !is_rd) op = classify(byte_in);
  end
endmodule

// File: rtl/lcdc_addr.sv
module lcdc_addr
  import lcdc_pkg::*;
#(
  parameter int NUM_PAGES = 9,
  parameter int NUM_COLS  = 132,
  localparam int PAGE_W   = $clog2(NUM_PAGES),
  localparam logic [7:0] LAST_COL = 8'(NUM_COLS - 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  op_e               op,
  input  logic [7:0]        arg,
  input  logic              adv,
  output logic [PAGE_W-1:0] page,
  output logic [7:0]        col
);
  logic page_ok;
  assign page_ok = ({4'b0, arg[3:0]} < 8'(NUM_PAGES));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page <= '0;
      col  <= '0;
    end else begin
      case (op)
        OP_PAGE:  if (page_ok) page <= arg[PAGE_W-1:0];
        OP_COLHI: col[7:4] <= arg[3:0];
        OP_COLLO: col[3:0] <= arg[3:0];
        OP_SRST: begin
          page <= '0;
          col  <= '0;
        end
        default:  if (adv) col <= next_col(col, LAST_COL);
      endcase
    end
  end
endmodule

// File: rtl/lcdc_mem.sv
module lcdc_mem #(
  parameter int NUM_PAGES = 9,
  parameter int NUM_COLS  = 132,
  localparam int PAGE_W   = $clog2(NUM_PAGES),
  localparam int DEPTH    = NUM_PAGES * NUM_COLS,
  localparam int IDX_W    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic              rd,
  input  logic [PAGE_W-1:0] page,
  input  logic [7:0]        col,
  input  logic [7:0]        wdata,
  output logic [7:0]        latch
);
  logic [7:0]       mem [DEPTH];
  logic [IDX_W-1:0] idx;
  logic             in_range;

  assign in_range = ({24'b0, col} < NUM_COLS);
  assign idx = IDX_W'(page) * IDX_W'(NUM_COLS) + IDX_W'(col);

  always_ff @(posedge clk) begin
    if (we && in_range) mem[idx] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  latch <= '0;
    else if (rd) latch <= in_range ? mem[idx] : 8'h00;
  end
endmodule

// File: rtl/lcd_cmd_ctl.sv
module lcd_cmd_ctl
  import lcdc_pkg::*;
#(
  parameter int NUM_PAGES = 9,
  parameter int NUM_COLS  = 132,
  localparam int PAGE_W   = $clog2(NUM_PAGES),
  localparam int ICON_PG  = NUM_PAGES - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_stb,
  input  logic              bus_dat,
  input  logic              bus_rd,
  input  logic [7:0]        bus_din,
  output logic [7:0]        bus_dout,
  output logic [PAGE_W-1:0] ram_page,
  output logic [7:0]        ram_col,
  output logic              ram_we,
  output logic [7:0]        ram_wdata,
  output logic              disp_on,
  output logic              inverse,
  output logic              all_on,
  output logic              seg_rev,
  output logic              com_rev,
  output logic              bias_7th,
  output logic              rmw_on,
  output logic [5:0]        start_line,
  output logic [2:0]        pwr_ctl
);
  op_e  op;
  logic data_rd_evt, data_wr_evt, status_rd_evt, col_adv, col_ok;
  logic [7:0] rd_latch;

  assign data_rd_evt   = bus_stb &  bus_dat &  bus_rd;
  assign data_wr_evt   = bus_stb &  bus_dat & ~bus_rd;
  assign status_rd_evt = bus_stb & ~bus_dat &  bus_rd;
  assign col_adv       = (data_rd_evt & ~rmw_on) | data_wr_evt;
  assign col_ok        = ({24'b0, ram_col} < NUM_COLS);
  assign ram_we        = data_wr_evt & col_ok;
  assign ram_wdata     = (int'(ram_page) == ICON_PG) ? {7'b0, bus_din[0]} : bus_din;

  lcdc_decode u_dec (
    .stb(bus_stb), .is_dat(bus_dat), .is_rd(bus_rd), .byte_in(bus_din), .op(op)
  );

  lcdc_addr #(.NUM_PAGES(NUM_PAGES), .NUM_COLS(NUM_COLS)) u_addr (
    .clk(clk), .rst_n(rst_n), .op(op), .arg(bus_din), .adv(col_adv),
    .page(ram_page), .col(ram_col)
  );

  lcdc_mem #(.NUM_PAGES(NUM_PAGES), .NUM_COLS(NUM_COLS)) u_mem (
    .clk(clk), .rst_n(rst_n), .we(ram_we), .rd(data_rd_evt),
    .page(ram_page), .col(ram_col), .wdata(ram_wdata), .latch(rd_latch)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      disp_on <= 1'b0; inverse <= 1'b0; all_on <= 1'b0; seg_rev <= 1'b0;
      com_rev <= 1'b0; bias_7th <= 1'b0; rmw_on <= 1'b0;
      start_line <= '0; pwr_ctl <= '0;
    end else begin
      case (op)
        OP_DISP:    disp_on    <= bus_din[0];
        OP_SEG:     seg_rev    <= bus_din[0];
        OP_INV:     inverse    <= bus_din[0];
        OP_ALLON:   all_on     <= bus_din[0];
        OP_BIAS:    bias_7th   <= bus_din[0];
        OP_COMDIR:  com_rev    <= bus_din[3];
        OP_LINE:    start_line <= bus_din[5:0];
        OP_PWR:     pwr_ctl    <= bus_din[2:0];
        OP_RMW_ON:  rmw_on     <= 1'b1;
        OP_RMW_OFF: rmw_on     <= 1'b0;
        OP_SRST: begin
          rmw_on     <= 1'b0;
          start_line <= '0;
          com_rev    <= 1'b0;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             bus_dout <= '0;
    else if (status_rd_evt) bus_dout <= status_byte(seg_rev, disp_on);
    else if (data_rd_evt)   bus_dout <= rd_latch;
  end
endmodule

// File: rtl/lcdc_chk.sv
module lcdc_chk #(
  parameter int NUM_COLS = 132,
  parameter int PAGE_W   = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              data_rd_evt,
  input logic              data_wr_evt,
  input logic              status_rd_evt,
  input logic              rmw_on,
  input logic              seg_rev,
  input logic              ram_we,
  input logic [PAGE_W-1:0] ram_page,
  input logic [7:0]        ram_col,
  input logic [7:0]        bus_dout
);
  localparam logic [7:0] LAST = 8'(NUM_COLS - 1);

  a_r3_col_sticks: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd_evt || data_wr_evt) && ram_col == LAST |=> ram_col == LAST);

  a_r3_page_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd_evt || data_wr_evt) |=> $stable(ram_page));

  a_r3_write_advance: assert property (@(posedge clk) disable iff (!rst_n)
    data_wr_evt && ram_col < LAST |=> ram_col == $past(ram_col) + 8'd1);

  a_r5_rmw_read_hold: assert property (@(posedge clk) disable iff (!rst_n)
    data_rd_evt && rmw_on |=> $stable(ram_col));

  a_r7_status_bits: assert property (@(posedge clk) disable iff (!rst_n)
    status_rd_evt |=> bus_dout[3:0] == 4'h0 && bus_dout[7] == 1'b0 && bus_dout[6] != seg_rev);

  a_r11_no_oob_write: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> ram_col <= LAST);
endmodule

bind lcd_cmd_ctl lcdc_chk #(.NUM_COLS(NUM_COLS), .PAGE_W(PAGE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .data_rd_evt(data_rd_evt), .data_wr_evt(data_wr_evt),
  .status_rd_evt(status_rd_evt), .rmw_on(rmw_on), .seg_rev(seg_rev),
  .ram_we(ram_we), .ram_page(ram_page), .ram_col(ram_col), .bus_dout(bus_dout)
);

// File: tb/test_lcd_cmd_ctl.sv
module test_lcd_cmd_ctl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_stb = 1'b0, bus_dat = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_din = '0, bus_dout, ram_wdata, ram_col;
  logic [3:0] ram_page;
  logic ram_we, disp_on, inverse, all_on, seg_rev, com_rev, bias_7th, rmw_on;
  logic [5:0] start_line;
  logic [2:0] pwr_ctl;
  int n_chk = 0, n_bad = 0;
  logic [7:0] last_latch = 8'h00;
  logic saw_we;

  always #2 clk = ~clk;

  lcd_cmd_ctl i_lcd_cmd_ctl (.*);

  task automatic check(input string req, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic xfer(input logic d, input logic r, input logic [7:0] b);
    bus_stb = 1'b1; bus_dat = d; bus_rd = r; bus_din = b;
    #1 saw_we = ram_we;
    @(negedge clk);
    bus_stb = 1'b0; bus_dat = 1'b0; bus_rd = 1'b0;
  endtask

  task automatic cmd(input logic [7:0] b); xfer(1'b0, 1'b0, b); endtask
  task automatic wr(input logic [7:0] b);  xfer(1'b1, 1'b0, b); endtask
  task automatic set_col(input logic [7:0] c);
    cmd({4'h1, c[7:4]}); cmd({4'h0, c[3:0]});
  endtask

  task automatic t_reset;
    check("R1 disp_on", disp_on, 0); check("R1 inverse", inverse, 0);
    check("R1 all_on", all_on, 0);   check("R1 seg_rev", seg_rev, 0);
    check("R1 com_rev", com_rev, 0); check("R1 bias", bias_7th, 0);
    check("R1 rmw", rmw_on, 0);      check("R1 line", start_line, 0);
    check("R1 pwr", pwr_ctl, 0);     check("R1 page", ram_page, 0);
    check("R1 col", ram_col, 0);     check("R1 dout", bus_dout, 0);
  endtask

  task automatic t_modes;
    cmd(8'hAF); check("R8 display on", disp_on, 1);
    cmd(8'hA1); check("R8 seg reversed", seg_rev, 1);
    cmd(8'hA7); check("R8 inverse on", inverse, 1);
    cmd(8'hA5); check("R8 entire on", all_on, 1);
    cmd(8'hA3); check("R8 bias 1/7", bias_7th, 1);
    cmd(8'hAE); cmd(8'hA0); cmd(8'hA6); cmd(8'hA4); cmd(8'hA2);
    check("R8 all cleared", {disp_on, seg_rev, inverse, all_on, bias_7th}, 0);
  endtask

  task automatic t_fields;
    cmd(8'hC8); check("R9 com dir set", com_rev, 1);
    cmd(8'hC7); check("R9 com dir clear", com_rev, 0);
    cmd(8'h6A); check("R9 start line", start_line, 6'h2A);
    cmd(8'h2D); check("R9 power field", pwr_ctl, 3'b101);
  endtask

  task automatic t_addr_set;
    cmd(8'hB3); check("R4 page 3", ram_page, 3);
    set_col(8'h82); check("R2 column", ram_col, 8'h82);
    cmd(8'hBC); check("R4 page 12 ignored", ram_page, 3);
  endtask

  task automatic t_write_read;
    cmd(8'hB2); set_col(8'h05);
    wr(8'hAA); check("R3 col advance", ram_col, 6);
    wr(8'hBB); wr(8'hCC); check("R3 col after 3 writes", ram_col, 8);
    set_col(8'h05);
    xfer(1'b1, 1'b1, 8'h00); check("R6 dummy read stale", bus_dout, last_latch);
    check("R3 read advances", ram_col, 6);
    xfer(1'b1, 1'b1, 8'h00); check("R6 second read", bus_dout, 8'hAA);
    xfer(1'b1, 1'b1, 8'h00); check("R6 third read", bus_dout, 8'hBB);
    last_latch = 8'hCC;
  endtask

  task automatic t_saturate;
    cmd(8'hB1); set_col(8'h82);
    wr(8'h11); check("R3 reach last", ram_col, 8'h83);
    wr(8'h22); wr(8'h33);
    check("R3 stays at last", ram_col, 8'h83); check("R3 page kept", ram_page, 1);
    set_col(8'h82); check("R3 stop released", ram_col, 8'h82);
    xfer(1'b1, 1'b1, 8'h00); check("R6 dummy stale", bus_dout, last_latch);
    xfer(1'b1, 1'b1, 8'h00); check("R6 read 0x82", bus_dout, 8'h11);
    xfer(1'b1, 1'b1, 8'h00); check("R3 last overwritten", bus_dout, 8'h33);
    last_latch = 8'h33;
  endtask

  task automatic t_rmw;
    cmd(8'hB0); set_col(8'h10);
    cmd(8'hE0); check("R5 rmw on", rmw_on, 1);
    xfer(1'b1, 1'b1, 8'h00); xfer(1'b1, 1'b1, 8'h00);
    check("R5 reads hold col", ram_col, 8'h10);
    wr(8'h5A); check("R5 write advances", ram_col, 8'h11);
    cmd(8'hEE); check("R5 rmw off", rmw_on, 0);
    xfer(1'b1, 1'b1, 8'h00); check("R5 read advances again", ram_col, 8'h12);
    last_latch = 8'h00;
  endtask

  task automatic t_icon;
    cmd(8'hB8); check("R4 page 8", ram_page, 8);
    set_col(8'h00); wr(8'hFF);
    set_col(8'h00);
    xfer(1'b1, 1'b1, 8'h00); xfer(1'b1, 1'b1, 8'h00);
    check("R4 icon keeps bit 0", bus_dout, 8'h01);
    cmd(8'hB9); check("R4 page 9 ignored", ram_page, 8);
  endtask

  task automatic t_oob;
    set_col(8'h90);
    wr(8'h77); check("R11 no write enable", saw_we, 0);
    check("R11 col holds", ram_col, 8'h90);
    set_col(8'h03); wr(8'h77); check("R11 in-range write enable", saw_we, 1);
  endtask

  task automatic t_status;
    cmd(8'hA1); cmd(8'hAF);
    xfer(1'b0, 1'b1, 8'h00); check("R7 status seg rev, on", bus_dout, 8'h00);
    cmd(8'hA0); cmd(8'hAE);
    xfer(1'b0, 1'b1, 8'h00); check("R7 status normal, off", bus_dout, 8'h60);
  endtask

  task automatic t_soft_reset;
    cmd(8'hAF); cmd(8'hA7); cmd(8'hA5); cmd(8'hA1); cmd(8'hA3); cmd(8'h2E);
    cmd(8'h49); cmd(8'hC8); cmd(8'hE0); cmd(8'hB4); set_col(8'h33);
    cmd(8'hE2);
    check("R10 rmw cleared", rmw_on, 0);  check("R10 line cleared", start_line, 0);
    check("R10 com cleared", com_rev, 0); check("R10 page cleared", ram_page, 0);
    check("R10 col cleared", ram_col, 0);
    check("R10 modes kept", {disp_on, inverse, all_on, seg_rev, bias_7th}, 5'b11111);
    check("R10 power kept", pwr_ctl, 3'b110);
  endtask

  initial begin
    #(4 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got hang expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset; t_modes; t_fields; t_addr_set; t_write_read; t_saturate;
    t_rmw; t_icon; t_oob; t_status; t_soft_reset;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule